// File: doc/BRIEF.md
# Target-Cycle Sequencer for an Emulated Unit

This block paces one emulated unit through its target cycles while the host clock runs freely underneath. It looks at a ready flag from every input channel (a token is waiting) and a space flag from every output channel (one more token fits). When all of them are set and no target cycle is open, it raises a one-host-cycle start pulse toward the unit. The unit then takes as many host cycles as it needs and answers with done. On the done cycle the sequencer pops one token from every input channel and pushes one token into every output channel, and it adds one to a count of finished target cycles.

A unit that needs only one host cycle per target cycle can tie done to start. Such a unit must advance its state only on host cycles where start is high. The sequencer handles start and done in the same cycle as an immediate completion, so a tied unit can run one target cycle per host cycle while its channels keep up. Channel storage and the unit itself sit outside this block.

Top module: `tcw_target_wrapper`

## Requirements
- R1: After reset `unit_start`, every bit of `in_deq` and `out_enq` are 0, `tcycle_count` is 0 and no target cycle is open.
- R2: With no target cycle open, `unit_start` is 1 in the same host cycle in which every bit of `in_ready` and every bit of `out_space` is 1.
- R3: `unit_start` is 0 in any host cycle where at least one bit of `in_ready` or of `out_space` is 0.
- R4: After a start that is not met by `unit_done` in the same cycle, a target cycle is open and `unit_start` stays 0 until a `unit_done` has been accepted, whatever the channel flags do.
- R5: In the host cycle where `unit_done` is accepted, every bit of `in_deq` and of `out_enq` is 1; in every other host cycle all of those bits are 0.
- R6: `unit_done` high in the same cycle as `unit_start` completes that target cycle at once, so a unit with done tied to start finishes one target cycle per host cycle while the flags stay set.
- R7: `unit_done` with no target cycle open and no start in that cycle is ignored: no dequeue, no enqueue, count unchanged.
- R8: `tcycle_count` rises by exactly 1 on the clock edge after each accepted `unit_done` and holds otherwise.
- R9: The number of host cycles between start and done may differ from one target cycle to the next, and changes of `in_ready` or `out_space` while a target cycle is open do not stop the dequeue and enqueue at done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_ready | input | N_IN | Per input channel: a token is waiting |
| out_space | input | N_OUT | Per output channel: one more token fits |
| unit_done | input | 1 | Unit has finished the open target cycle |
| unit_start | output | 1 | Begin the next target cycle (one host cycle) |
| in_deq | output | N_IN | Pop one token from each input channel |
| out_enq | output | N_OUT | Push the unit's output into each output channel |
| tcycle_count | output | CNT_W | Number of completed target cycles |

## Verification
The bench targets a done that lands in the very cycle of start: a design that ignored it would hang or issue a second start, so the tied-unit test would see missed completions. It drops input readiness in the middle of an open target cycle, where a design that re-checked the flags at done would lose a dequeue and leave tokens in the channels. A stray done while idle must leave the count alone; a design accepting it would pop tokens that were never consumed. A random run with a token model per channel catches any pop from an empty channel or any mismatch between completions and the count.

// File: rtl/tcw_pkg.sv
package tcw_pkg;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

    typedef struct packed {
        phase_e phase;
    } seq_state_t;

endpackage

// File: rtl/tcw_flag_and.sv
module tcw_flag_and #(
    parameter int W = 4
) (
    input  logic [W-1:0] flags,
    output logic         all_set
);
    logic [W:0] chain;

    assign chain[0] = 1'b1;

    generate
        for (genvar i = 0; i < W; i++) begin : g_chain
            assign chain[i+1] = chain[i] & flags[i];
        end
    endgenerate

    assign all_set = chain[W];
endmodule

// File: rtl/tcw_seq_fsm.sv
module tcw_seq_fsm
    import tcw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic inputs_ok,
    input  logic outputs_ok,
    input  logic unit_done,
    output logic unit_start,
    output logic complete,
    output logic busy
);
    seq_state_t st_d, st_q;
    logic       start_d;
    logic       complete_d;

    always_comb begin
        st_d       = st_q;
        start_d    = 1'b0;
        complete_d = 1'b0;
        case (st_q.phase)
            PH_IDLE: begin
                if (inputs_ok && outputs_ok) begin
                    start_d = 1'b1;
                    if (unit_done) begin
                        complete_d = 1'b1;
                    end else begin
                        st_d.phase = PH_RUN;
                    end
                end
            end
            PH_RUN: begin
                if (unit_done) begin
                    complete_d = 1'b1;
                    st_d.phase = PH_IDLE;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.phase <= PH_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign unit_start = start_d;
    assign complete   = complete_d;
    assign busy       = (st_q.phase == PH_RUN);
endmodule

// File: rtl/tcw_cycle_counter.sv
module tcw_cycle_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] count
);
    logic [W-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q;
        if (inc) begin
            count_d = count_q + {{(W-1){1'b0}}, 1'b1};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else begin
            count_q <= count_d;
        end
    end

    assign count = count_q;
endmodule

// File: rtl/tcw_target_wrapper.sv
module tcw_target_wrapper #(
    parameter int N_IN  = 3,
    parameter int N_OUT = 2,
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_IN-1:0]  in_ready,
    input  logic [N_OUT-1:0] out_space,
    input  logic             unit_done,
    output logic             unit_start,
    output logic [N_IN-1:0]  in_deq,
    output logic [N_OUT-1:0] out_enq,
    output logic [CNT_W-1:0] tcycle_count
);
    logic inputs_ok;
    logic outputs_ok;
    logic complete;
    logic busy;

    tcw_flag_and #(.W(N_IN)) u_in_and (
        .flags   (in_ready),
        .all_set (inputs_ok)
    );

    tcw_flag_and #(.W(N_OUT)) u_out_and (
        .flags   (out_space),
        .all_set (outputs_ok)
    );

    tcw_seq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .inputs_ok  (inputs_ok),
        .outputs_ok (outputs_ok),
        .unit_done  (unit_done),
        .unit_start (unit_start),
        .complete   (complete),
        .busy       (busy)
    );

    tcw_cycle_counter #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (complete),
        .count (tcycle_count)
    );

    assign in_deq  = {N_IN{complete}};
    assign out_enq = {N_OUT{complete}};
endmodule

// File: rtl/tcw_target_wrapper_chk.sv
module tcw_target_wrapper_chk #(
    parameter int N_IN  = 3,
    parameter int N_OUT = 2,
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_IN-1:0]  in_ready,
    input logic [N_OUT-1:0] out_space,
    input logic             unit_done,
    input logic             unit_start,
    input logic [N_IN-1:0]  in_deq,
    input logic [N_OUT-1:0] out_enq,
    input logic [CNT_W-1:0] tcycle_count,
    input logic             busy
);
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (tcycle_count == '0) && !busy);

    p_start_needs_flags_r3: assert property (@(posedge clk) disable iff (!rst_n)
        unit_start |-> ((&in_ready) && (&out_space)));

    p_start_when_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && (&in_ready) && (&out_space)) |-> unit_start);

    p_no_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !unit_start);

    p_start_opens_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (unit_start && !unit_done) |=> busy);

    p_pop_only_on_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|in_deq) |-> unit_done);

    p_pop_push_agree_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((|in_deq) == (|out_enq)) && ((in_deq == '0) || (&in_deq))
        && ((out_enq == '0) || (&out_enq)));

    p_done_run_pops_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && unit_done) |-> (&in_deq));

    p_tied_completes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (unit_start && unit_done) |-> (&out_enq));

    p_stray_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !unit_start && unit_done) |-> (in_deq == '0));

    p_count_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|in_deq) |=> (tcycle_count == $past(tcycle_count) + 1'b1));

    p_count_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(|in_deq) |=> $stable(tcycle_count));
endmodule

bind tcw_target_wrapper tcw_target_wrapper_chk #(
    .N_IN  (N_IN),
    .N_OUT (N_OUT),
    .CNT_W (CNT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_ready     (in_ready),
    .out_space    (out_space),
    .unit_done    (unit_done),
    .unit_start   (unit_start),
    .in_deq       (in_deq),
    .out_enq      (out_enq),
    .tcycle_count (tcycle_count),
    .busy         (busy)
);

// File: tb/tb_tcw_target_wrapper.sv
`timescale 1ns/1ps
module tb_tcw_target_wrapper;
    localparam int N_IN  = 3;
    localparam int N_OUT = 2;
    localparam int CNT_W = 32;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [N_IN-1:0]  in_ready;
    logic [N_OUT-1:0] out_space;
    logic             done_drv;
    logic             tied;
    logic             unit_done;
    logic             unit_start;
    logic [N_IN-1:0]  in_deq;
    logic [N_OUT-1:0] out_enq;
    logic [CNT_W-1:0] tcycle_count;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_count = 0;

    always #5 clk = ~clk;

    assign unit_done = tied ? unit_start : done_drv;

    tcw_target_wrapper #(.N_IN(N_IN), .N_OUT(N_OUT), .CNT_W(CNT_W)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_ready     (in_ready),
        .out_space    (out_space),
        .unit_done    (unit_done),
        .unit_start   (unit_start),
        .in_deq       (in_deq),
        .out_enq      (out_enq),
        .tcycle_count (tcycle_count)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic after_edge();
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; in_ready = '0; out_space = '0; done_drv = 1'b0; tied = 1'b0;
        repeat (3) after_edge();
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 start", {31'd0, unit_start}, 32'd0);
        chk("R1 deq", {29'd0, in_deq}, 32'd0);
        chk("R1 enq", {30'd0, out_enq}, 32'd0);
        chk("R1 count", tcycle_count, 32'd0);
    endtask

    task automatic t_gating();
        after_edge();
        in_ready = 3'b101; out_space = 2'b11;
        @(negedge clk);
        chk("R3 input missing", {31'd0, unit_start}, 32'd0);
        in_ready = 3'b111; out_space = 2'b10;
        @(negedge clk);
        chk("R3 space missing", {31'd0, unit_start}, 32'd0);
        chk("R7 count idle", tcycle_count, exp_count);
        in_ready = '0; out_space = '0;
    endtask

    task automatic t_variable(input int wait_cycles);
        after_edge();
        in_ready = '1; out_space = '1;
        @(negedge clk);
        chk("R2 start", {31'd0, unit_start}, 32'd1);
        after_edge();
        in_ready = 3'b010; out_space = 2'b01;
        for (int k = 0; k < wait_cycles; k++) begin
            if (k == 1) begin
                in_ready = '1; out_space = '1;
            end
            @(negedge clk);
            chk("R4 no restart", {31'd0, unit_start}, 32'd0);
            chk("R5 no pop while open", {29'd0, in_deq}, 32'd0);
            after_edge();
        end
        in_ready = 3'b001;
        done_drv = 1'b1;
        @(negedge clk);
        chk("R9 pop at done", {29'd0, in_deq}, 32'd7);
        chk("R5 push at done", {30'd0, out_enq}, 32'd3);
        exp_count++;
        after_edge();
        done_drv = 1'b0; in_ready = '0; out_space = '0;
        @(negedge clk);
        chk("R8 count step", tcycle_count, exp_count);
    endtask

    task automatic t_stray_done();
        after_edge();
        in_ready = 3'b011; out_space = '1; done_drv = 1'b1;
        @(negedge clk);
        chk("R7 no pop", {29'd0, in_deq}, 32'd0);
        chk("R7 no push", {30'd0, out_enq}, 32'd0);
        after_edge();
        done_drv = 1'b0;
        @(negedge clk);
        chk("R7 count held", tcycle_count, exp_count);
        in_ready = '0; out_space = '0;
    endtask

    task automatic t_tied();
        after_edge();
        tied = 1'b1; in_ready = '1; out_space = '1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R6 start each cycle", {31'd0, unit_start}, 32'd1);
            chk("R6 pop each cycle", {29'd0, in_deq}, 32'd7);
            after_edge();
            exp_count++;
        end
        in_ready = '0;
        @(negedge clk);
        chk("R6 count after run", tcycle_count, exp_count);
        chk("R3 stop when empty", {31'd0, unit_start}, 32'd0);
        after_edge();
        tied = 1'b0; out_space = '0;
    endtask

    task automatic t_random();
        int tokens [N_IN];
        int pops   [N_IN];
        bit open_tc = 0;
        int done_cnt = 0;
        int bad = 0;
        int start_cnt = 0;
        logic [31:0] base = tcycle_count;
        for (int i = 0; i < N_IN; i++) begin
            tokens[i] = 0; pops[i] = 0;
        end
        for (int cyc = 0; cyc < 2000; cyc++) begin
            after_edge();
            for (int i = 0; i < N_IN; i++) begin
                if (($urandom % 4) == 0) tokens[i]++;
                in_ready[i] = (tokens[i] > 0);
            end
            out_space = 2'($urandom % 4);
            done_drv  = (($urandom % 3) == 0);
            @(negedge clk);
            if (unit_start) start_cnt++;
            if ({29'd0, in_deq} !== ((done_drv && (open_tc || unit_start)) ? 32'd7 : 32'd0))
                bad++;
            if (|in_deq) begin
                done_cnt++;
                for (int i = 0; i < N_IN; i++) begin
                    if (tokens[i] == 0) bad++;
                    else tokens[i]--;
                    pops[i]++;
                end
            end
            if (unit_start && !done_drv) open_tc = 1;
            else if (open_tc && done_drv) open_tc = 0;
        end
        after_edge();
        done_drv = 1'b1; in_ready = '0; out_space = '0;
        @(negedge clk);
        if (open_tc) done_cnt++;
        after_edge();
        done_drv = 1'b0;
        @(negedge clk);
        chk("R5 random pop model", bad, 0);
        for (int i = 0; i < N_IN; i++)
            chk("R9 pops match starts", pops[i] + (open_tc ? 1 : 0), start_cnt);
        chk("R8 random count", tcycle_count - base, done_cnt);
        exp_count = tcycle_count;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_gating();
        t_variable(1);
        t_variable(4);
        t_stray_done();
        t_tied();
        t_variable(2);
        t_random();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule